// File: doc/BRIEF.md
# Transactional Cache-Line Conflict Tracker

This block follows speculative memory transactions for one core at cache-line granularity. The core sends begin, end and explicit-abort commands. It also reports every load or store line address that it touches. The memory side presents snooped remote requests, eviction notices and demand-downgrade notices. The block keeps a small table of line tags, each with a read mark and a write mark, plus a nesting counter. From these it decides whether the transaction commits or aborts.

Nesting is flat. A begin inside a transaction only deepens the count, and only the end that brings the count back to zero commits. An abort from any source discards the whole nest, clears every mark and resets the depth. The abort is reported as a single-cycle pulse with a cause code. When a remote request or a downgrade takes away a speculatively written line, the block also flags that the snoop must be served from memory instead of being forwarded.

Top module: `txn_conflict_tracker`

## Requirements
- R1: After reset, depth_o is 0 and commit_o, abort_o, fwd_fail_o and cause_o are all 0.
- R2: Each begin_i raises depth_o by one and each end_i lowers it by one. An end_i while depth_o is 0 is ignored: depth stays 0 and no pulse follows.
- R3: commit_o pulses only when an end_i (without begin_i) arrives at depth 1, and depth_o then becomes 0. An end_i at a greater depth does not commit.
- R4: While depth_o is nonzero, an access with acc_write_i=0 sets the read mark of its line and one with acc_write_i=1 sets the write mark. Accesses made while depth_o is 0 leave no mark.
- R5: In a transaction, a snoop (snp_write_i either value) to a line holding either mark aborts with cause 1 (conflict). A snoop to an unmarked line has no effect.
- R6: fwd_fail_o pulses together with the abort when a snoop or a downgrade notice in a transaction hits a line that carries the write mark. Otherwise it stays 0.
- R7: An eviction of a write-marked line aborts with cause 2. Evicting a line that carries only a read mark, or no mark, has no effect.
- R8: A downgrade notice for a write-marked line aborts with cause 3. A downgrade of a line that is only read-marked is ignored.
- R9: abort_i in a transaction aborts with cause 4. abort_i while depth_o is 0 is ignored.
- R10: A begin_i at depth 15 aborts with cause 5 (overflow).
- R11: The table tracks 16 distinct lines. A transactional access to a 17th new line aborts with cause 2. Repeat accesses to a tracked line take no new entry.
- R12: Every abort sets depth_o to 0. Every abort and every commit clears all marks, so later snoops to those lines do not conflict.
- R13: When several abort causes occur in one cycle, the reported cause is picked in the order explicit, conflict, downgrade, capacity, overflow. Any abort suppresses a commit in the same cycle. All tests use the table state from the start of the cycle.
- R14: commit_o, abort_o, cause_o and fwd_fail_o are registered. They are valid for exactly the one cycle after the triggering edge, and cause_o is 0 when abort_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| begin_i | input | 1 | Transaction begin command |
| end_i | input | 1 | Transaction end command |
| abort_i | input | 1 | Explicit abort command |
| acc_valid_i | input | 1 | Local access valid |
| acc_write_i | input | 1 | Local access is a store |
| acc_line_i | input | LINE_W | Local access line address |
| snp_valid_i | input | 1 | Remote snoop valid |
| snp_write_i | input | 1 | Remote snoop is a write request |
| snp_line_i | input | LINE_W | Remote snoop line address |
| evict_valid_i | input | 1 | Line eviction notice |
| evict_line_i | input | LINE_W | Evicted line address |
| dgrade_valid_i | input | 1 | Demand-downgrade notice |
| dgrade_line_i | input | LINE_W | Downgraded line address |
| depth_o | output | DEPTH_W | Current nesting depth |
| commit_o | output | 1 | Commit pulse |
| abort_o | output | 1 | Abort pulse |
| cause_o | output | 3 | Abort cause: 1 conflict, 2 capacity, 3 downgrade, 4 explicit, 5 overflow |
| fwd_fail_o | output | 1 | Snoop must be served from memory |

## Verification
The assertions rely on the core never holding a begin at depth 15 without that begin counting as an overflow. They also rely on the clean/dirty status of a line being implied by its write mark alone, so eviction and downgrade notices carry no dirty flag of their own. The random stimulus draws every input independently each cycle. Line addresses come from small pools, so hits, misses, a full table and simultaneous causes all occur. A cycle-level reference model in the bench follows the stated priority and uses the table state from the start of each cycle. Directed sequences reach the depth-15 overflow and the 17th-line capacity case, which random draws rarely hit.

// File: rtl/txn_pkg.sv
package txn_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE      = 3'd0,
    CAUSE_CONFLICT  = 3'd1,
    CAUSE_CAPACITY  = 3'd2,
    CAUSE_DOWNGRADE = 3'd3,
    CAUSE_EXPLICIT  = 3'd4,
    CAUSE_OVERFLOW  = 3'd5
  } abort_cause_e;
endpackage

// File: rtl/txn_line_table.sv
module txn_line_table #(
  parameter int ENTRIES = 16,
  parameter int LINE_W  = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              upd_i,
  input  logic              upd_wr_i,
  input  logic [LINE_W-1:0] acc_line_i,
  input  logic [LINE_W-1:0] snp_line_i,
  input  logic [LINE_W-1:0] ev_line_i,
  input  logic [LINE_W-1:0] dg_line_i,
  output logic              acc_hit_o,
  output logic              full_o,
  output logic              snp_hit_o,
  output logic              snp_wr_hit_o,
  output logic              ev_wr_hit_o,
  output logic              dg_wr_hit_o
);
  logic [LINE_W-1:0] tag_q [ENTRIES];
  logic [ENTRIES-1:0] rd_q, wr_q, used;
  logic [ENTRIES-1:0] acc_m, snp_m, ev_m, dg_m, alloc_oh;

  assign used = rd_q | wr_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign acc_m[i] = used[i] && (tag_q[i] == acc_line_i);
    assign snp_m[i] = used[i] && (tag_q[i] == snp_line_i);
    assign ev_m[i]  = used[i] && (tag_q[i] == ev_line_i);
    assign dg_m[i]  = used[i] && (tag_q[i] == dg_line_i);
  end

  assign acc_hit_o    = |acc_m;
  assign full_o       = &used;
  assign snp_hit_o    = |snp_m;
  assign snp_wr_hit_o = |(snp_m & wr_q);
  assign ev_wr_hit_o  = |(ev_m & wr_q);
  assign dg_wr_hit_o  = |(dg_m & wr_q);

  // lowest free slot
  always_comb begin
    logic found;
    found    = 1'b0;
    alloc_oh = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!used[i] && !found) begin
        alloc_oh[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic sel;
    assign sel = upd_i && (acc_m[i] || (!acc_hit_o && alloc_oh[i]));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_q[i]  <= 1'b0;
        wr_q[i]  <= 1'b0;
        tag_q[i] <= '0;
      end else if (clear_i) begin
        rd_q[i] <= 1'b0;
        wr_q[i] <= 1'b0;
      end else if (sel) begin
        tag_q[i] <= acc_line_i;
        if (upd_wr_i) wr_q[i] <= 1'b1;
        else          rd_q[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/txn_nest_ctrl.sv
module txn_nest_ctrl #(
  parameter int DEPTH_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               begin_i,
  input  logic               end_i,
  input  logic               kill_i,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               at_max_o,
  output logic               at_one_o
);
  localparam logic [DEPTH_W-1:0] MAX_D = {DEPTH_W{1'b1}};
  localparam logic [DEPTH_W-1:0] ONE_D = DEPTH_W'(1);

  logic [DEPTH_W-1:0] depth_q;

  assign depth_o  = depth_q;
  assign at_max_o = (depth_q == MAX_D);
  assign at_one_o = (depth_q == ONE_D);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           depth_q <= '0;
    else if (kill_i)                       depth_q <= '0;
    else if (begin_i && !end_i)            depth_q <= depth_q + ONE_D;
    else if (end_i && !begin_i && depth_q != '0) depth_q <= depth_q - ONE_D;
  end
endmodule

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker
  import txn_pkg::*;
#(
  parameter int LINE_W  = 26,
  parameter int ENTRIES = 16,
  parameter int DEPTH_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               begin_i,
  input  logic               end_i,
  input  logic               abort_i,
  input  logic               acc_valid_i,
  input  logic               acc_write_i,
  input  logic [LINE_W-1:0]  acc_line_i,
  input  logic               snp_valid_i,
  input  logic               snp_write_i,
  input  logic [LINE_W-1:0]  snp_line_i,
  input  logic               evict_valid_i,
  input  logic [LINE_W-1:0]  evict_line_i,
  input  logic               dgrade_valid_i,
  input  logic [LINE_W-1:0]  dgrade_line_i,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               commit_o,
  output logic               abort_o,
  output logic [2:0]         cause_o,
  output logic               fwd_fail_o
);
  logic active, at_max, at_one;
  logic acc_hit, full, snp_hit, snp_wr_hit, ev_wr_hit, dg_wr_hit;
  logic xabt, conf, dgr, cap, ovf, any_abort, do_commit, fwd_d;
  abort_cause_e cause_d;
  logic commit_q, abort_q, fwd_q;
  abort_cause_e cause_q;

  assign active = (depth_o != '0);

  txn_nest_ctrl #(.DEPTH_W(DEPTH_W)) nest_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .begin_i (begin_i),
    .end_i   (end_i),
    .kill_i  (any_abort),
    .depth_o (depth_o),
    .at_max_o(at_max),
    .at_one_o(at_one)
  );

  txn_line_table #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) table_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (any_abort || do_commit),
    .upd_i       (active && acc_valid_i),
    .upd_wr_i    (acc_write_i),
    .acc_line_i  (acc_line_i),
    .snp_line_i  (snp_line_i),
    .ev_line_i   (evict_line_i),
    .dg_line_i   (dgrade_line_i),
    .acc_hit_o   (acc_hit),
    .full_o      (full),
    .snp_hit_o   (snp_hit),
    .snp_wr_hit_o(snp_wr_hit),
    .ev_wr_hit_o (ev_wr_hit),
    .dg_wr_hit_o (dg_wr_hit)
  );

  // snp_write_i kind does not matter: any remote hit on a marked line conflicts
  logic unused_snp_kind;
  assign unused_snp_kind = snp_write_i;

  assign xabt = active && abort_i;
  assign conf = active && snp_valid_i && snp_hit;
  assign dgr  = active && dgrade_valid_i && dg_wr_hit;
  assign cap  = active && ((evict_valid_i && ev_wr_hit) ||
                           (acc_valid_i && !acc_hit && full));
  assign ovf  = begin_i && at_max;
  assign any_abort = xabt || conf || dgr || cap || ovf;
  assign do_commit = !any_abort && end_i && !begin_i && at_one;
  assign fwd_d = active && ((snp_valid_i && snp_wr_hit) ||
                            (dgrade_valid_i && dg_wr_hit));

  always_comb begin
    if (xabt)      cause_d = CAUSE_EXPLICIT;
    else if (conf) cause_d = CAUSE_CONFLICT;
    else if (dgr)  cause_d = CAUSE_DOWNGRADE;
    else if (cap)  cause_d = CAUSE_CAPACITY;
    else if (ovf)  cause_d = CAUSE_OVERFLOW;
    else           cause_d = CAUSE_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_q <= 1'b0;
      abort_q  <= 1'b0;
      fwd_q    <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end else begin
      commit_q <= do_commit;
      abort_q  <= any_abort;
      fwd_q    <= fwd_d;
      cause_q  <= cause_d;
    end
  end

  assign commit_o   = commit_q;
  assign abort_o    = abort_q;
  assign cause_o    = cause_q;
  assign fwd_fail_o = fwd_q;
endmodule

// File: rtl/txn_tracker_chk.sv
module txn_tracker_chk #(
  parameter int DEPTH_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               begin_i,
  input logic               end_i,
  input logic [DEPTH_W-1:0] depth_o,
  input logic               commit_o,
  input logic               abort_o,
  input logic [2:0]         cause_o,
  input logic               fwd_fail_o
);
  localparam logic [DEPTH_W-1:0] MAX_D = {DEPTH_W{1'b1}};

  // R2
  stray_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_i && !begin_i && depth_o == '0) |=> (depth_o == '0 && !commit_o));

  // R3
  commit_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (depth_o == '0 && $past(depth_o) == DEPTH_W'(1)));

  // R6
  fwd_with_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_fail_o |-> abort_o);

  // R10
  overflow_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && cause_o == 3'd5) |-> ($past(depth_o) == MAX_D));

  // R12
  abort_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> depth_o == '0);

  // R13
  excl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && abort_o));

  // R14
  cause_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!abort_o |-> cause_o == 3'd0) and (abort_o |-> cause_o != 3'd0));

  // R2
  depth_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!abort_o && depth_o != $past(depth_o)) |->
      (depth_o == $past(depth_o) + DEPTH_W'(1) || depth_o == $past(depth_o) - DEPTH_W'(1)));
endmodule

bind txn_conflict_tracker txn_tracker_chk #(.DEPTH_W(DEPTH_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .begin_i   (begin_i),
  .end_i     (end_i),
  .depth_o   (depth_o),
  .commit_o  (commit_o),
  .abort_o   (abort_o),
  .cause_o   (cause_o),
  .fwd_fail_o(fwd_fail_o)
);

// File: tb/txn_conflict_tracker_tb_top.sv
`timescale 1ns/1ps
module txn_conflict_tracker_tb_top;
  localparam int LW = 26;
  localparam int NE = 16;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b, e, x, av, aw, sv, sw, ev, dv;
  logic [LW-1:0] al, sl, el, dl;
  logic [DW-1:0] depth;
  logic commit, abrt, fwd;
  logic [2:0] cause;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  txn_conflict_tracker #(.LINE_W(LW), .ENTRIES(NE), .DEPTH_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .begin_i(b), .end_i(e), .abort_i(x),
    .acc_valid_i(av), .acc_write_i(aw), .acc_line_i(al),
    .snp_valid_i(sv), .snp_write_i(sw), .snp_line_i(sl),
    .evict_valid_i(ev), .evict_line_i(el),
    .dgrade_valid_i(dv), .dgrade_line_i(dl),
    .depth_o(depth), .commit_o(commit), .abort_o(abrt),
    .cause_o(cause), .fwd_fail_o(fwd)
  );

  // reference model
  logic [LW-1:0] m_tag [NE];
  bit m_rd [NE];
  bit m_wr [NE];
  int m_d;
  bit x_commit, x_abort, x_fwd;
  int x_cause;

  function automatic logic [LW-1:0] ln(int i);
    return LW'(32'h400 + i);
  endfunction

  function automatic int find(logic [LW-1:0] l);
    for (int i = 0; i < NE; i++)
      if ((m_rd[i] || m_wr[i]) && m_tag[i] == l) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NE; i++) begin m_rd[i] = 0; m_wr[i] = 0; m_tag[i] = '0; end
    m_d = 0;
  endtask

  task automatic model_step();
    bit act, full, xa, cf, dg, cp, ov;
    int ai, si, ei, di;
    act = (m_d != 0);
    ai = find(al); si = find(sl); ei = find(el); di = find(dl);
    full = 1;
    for (int i = 0; i < NE; i++) if (!(m_rd[i] || m_wr[i])) full = 0;
    xa = act && x;
    cf = act && sv && si >= 0;
    dg = act && dv && di >= 0 && m_wr[di];
    cp = act && ((ev && ei >= 0 && m_wr[ei]) || (av && ai < 0 && full));
    ov = b && m_d == 15;
    x_abort = xa || cf || dg || cp || ov;
    x_cause = xa ? 4 : cf ? 1 : dg ? 3 : cp ? 2 : ov ? 5 : 0;
    x_fwd = act && ((sv && si >= 0 && m_wr[si]) || (dv && di >= 0 && m_wr[di]));
    x_commit = !x_abort && e && !b && m_d == 1;
    if (x_abort || x_commit) begin
      for (int i = 0; i < NE; i++) begin m_rd[i] = 0; m_wr[i] = 0; end
    end else if (act && av) begin
      int k;
      k = ai;
      if (k < 0)
        for (int i = NE - 1; i >= 0; i--) if (!(m_rd[i] || m_wr[i])) k = i;
      m_tag[k] = al;
      if (aw) m_wr[k] = 1; else m_rd[k] = 1;
    end
    if (x_abort) m_d = 0;
    else if (b && !e) m_d = m_d + 1;
    else if (e && !b && m_d != 0) m_d = m_d - 1;
  endtask

  task automatic idle_in();
    b = 0; e = 0; x = 0; av = 0; aw = 0; sv = 0; sw = 0; ev = 0; dv = 0;
    al = '0; sl = '0; el = '0; dl = '0;
  endtask

  task automatic chk(bit ok, string tag, string what, int act_v, int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act_v, exp_v);
    end
  endtask

  // apply one cycle of stimulus (already set on the signals), then compare
  task automatic step(string tag);
    int got, exp;
    model_step();
    @(posedge clk);
    @(negedge clk);
    got = {depth, commit, abrt, cause, fwd};
    exp = {m_d[DW-1:0], x_commit, x_abort, x_cause[2:0], x_fwd};
    chk(got == exp, tag, "{depth,commit,abort,cause,fwd}", got, exp);
    idle_in();
  endtask

  task automatic do_begin(string tag); idle_in(); b = 1; step(tag); endtask
  task automatic do_end(string tag);   idle_in(); e = 1; step(tag); endtask
  task automatic do_acc(bit w, int l, string tag);
    idle_in(); av = 1; aw = w; al = ln(l); step(tag);
  endtask
  task automatic do_snp(bit w, int l, string tag);
    idle_in(); sv = 1; sw = w; sl = ln(l); step(tag);
  endtask
  task automatic do_nop(string tag); idle_in(); step(tag); endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r;
    idle_in();
    model_reset();
    r = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(depth == 0 && !commit && !abrt && cause == 0 && !fwd, "R1", "reset outputs",
        {depth, commit, abrt, cause, fwd}, 0);

    // R2 stray end ignored
    do_end("R2 stray end");
    do_nop("R2 no pulse after stray end");
    // R2/R3 nesting
    do_begin("R2 begin depth1");
    do_begin("R2 begin depth2");
    chk(depth == 2, "R2", "depth after two begins", depth, 2);
    do_end("R3 inner end no commit");
    do_end("R3 outer end commits");
    chk(commit == 1 && depth == 0, "R3", "commit pulse", commit, 1);
    do_nop("R14 commit pulse drops");
    chk(commit == 0, "R14", "commit one cycle", commit, 0);

    // R4 accesses outside txn leave no mark
    do_acc(1, 1, "R4 store outside");
    do_begin("R4 begin");
    do_snp(1, 1, "R4 snoop unmarked no abort");
    chk(abrt == 0, "R4", "outside access untracked", abrt, 0);
    // R5 read mark + remote write
    do_acc(0, 2, "R4 load marks read");
    do_snp(1, 2, "R5 write snoop on read-set");
    chk(abrt && cause == 1 && !fwd, "R5", "conflict cause", cause, 1);
    // R6 remote read on write-set
    do_begin("R6 begin");
    do_acc(1, 3, "R4 store marks write");
    do_snp(0, 3, "R6 read snoop on write-set");
    chk(abrt && cause == 1 && fwd, "R6", "fwd fail", fwd, 1);

    // R7 eviction
    do_begin("R7 begin");
    do_acc(0, 4, "R7 load");
    idle_in(); ev = 1; el = ln(4); step("R7 evict read-only ignored");
    chk(abrt == 0 && depth == 1, "R7", "clean evict ignored", abrt, 0);
    do_acc(1, 4, "R7 store");
    idle_in(); ev = 1; el = ln(4); step("R7 evict dirty aborts");
    chk(abrt && cause == 2, "R7", "evict cause", cause, 2);

    // R8 downgrade
    do_begin("R8 begin");
    do_acc(0, 5, "R8 load");
    idle_in(); dv = 1; dl = ln(5); step("R8 downgrade clean ignored");
    do_acc(1, 6, "R8 store");
    idle_in(); dv = 1; dl = ln(6); step("R8 downgrade dirty");
    chk(abrt && cause == 3 && fwd, "R8", "downgrade cause", cause, 3);

    // R9 explicit
    idle_in(); x = 1; step("R9 explicit outside ignored");
    chk(abrt == 0, "R9", "explicit outside", abrt, 0);
    do_begin("R9 begin");
    do_begin("R9 nested");
    idle_in(); x = 1; step("R9 explicit abort");
    chk(abrt && cause == 4 && depth == 0, "R9", "explicit cause", cause, 4);

    // R10 overflow
    for (int i = 0; i < 15; i++) do_begin("R10 climb");
    chk(depth == 15, "R10", "depth at max", depth, 15);
    do_begin("R10 overflow");
    chk(abrt && cause == 5 && depth == 0, "R10", "overflow cause", cause, 5);

    // R11 capacity
    do_begin("R11 begin");
    for (int i = 0; i < NE; i++) do_acc(1, 100 + i, "R11 fill");
    do_acc(0, 100, "R11 repeat line no alloc");
    chk(abrt == 0, "R11", "repeat on full table", abrt, 0);
    do_acc(0, 200, "R11 17th line");
    chk(abrt && cause == 2, "R11", "capacity cause", cause, 2);

    // R12 commit clears marks
    do_begin("R12 begin");
    do_acc(1, 7, "R12 store");
    do_end("R12 commit");
    do_begin("R12 new txn");
    do_snp(0, 7, "R12 cleared after commit");
    chk(abrt == 0, "R12", "marks cleared", abrt, 0);
    do_end("R12 close");

    // R13 priority and abort over commit
    do_begin("R13 begin");
    do_acc(1, 8, "R13 store");
    idle_in(); x = 1; sv = 1; sl = ln(8); dv = 1; dl = ln(8); step("R13 explicit wins");
    chk(cause == 4 && fwd, "R13", "priority explicit", cause, 4);
    do_begin("R13 begin2");
    do_acc(0, 9, "R13 load");
    idle_in(); e = 1; sv = 1; sl = ln(9); step("R13 abort over commit");
    chk(abrt && !commit, "R13", "no commit on abort", commit, 0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      idle_in();
      b  = ($urandom % 100) < 14;
      e  = ($urandom % 100) < 10;
      x  = ($urandom % 100) < 2;
      av = ($urandom % 100) < 55;
      aw = $urandom % 2;
      al = ln($urandom % 20);
      sv = ($urandom % 100) < 6;
      sw = $urandom % 2;
      sl = ln($urandom % 40);
      ev = ($urandom % 100) < 4;
      el = ln($urandom % 20);
      dv = ($urandom % 100) < 3;
      dl = ln($urandom % 20);
      step("R13 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule